// File: doc/BRIEF.md
# Host Shared-Memory Mailbox Interface

This block is the host-facing slave of an embedded processor. An external host drives an asynchronous 16-bit bus with active-low chip select, read and write strobes and per-byte enables. The block synchronises the strobes into the core clock and decodes a 12-bit byte address. The lower half of the space reaches a 1K x 16 RAM that is shared with the core. The upper half holds a bank of 8-bit mailbox registers on the low byte lane. These are a receive data byte and a transmit data byte, two command bytes, and three interrupt status groups.

Each status group has a status byte that the core writes. It also has an enable byte, a detect byte that latches events and is cleared by writing 1, and, in groups one and three, an edge-select byte. An edge-select bit chooses whether its status bit raises detect on a 0-to-1 transition or for as long as it is high. The active-low interrupt output goes low while any enabled detect bit is set. When the condition clears it is driven high again, which stands in for releasing the line to its pull-up.

The core side has a synchronous RAM port and a synchronous register port, and both return read data one cycle after the address.

Top module: `mbx_top`

## Requirements
- R1: After reset `hostIrqN` is 1, `hostRdata` is 0 and every mailbox register, including all detect bits, reads 0.
- R2: A host access with `hostAddr[11]`=0 reaches RAM word `hostAddr[10:1]`. A host read always returns the whole 16-bit word, whatever `hostUbN`/`hostLbN` are.
- R3: On host RAM writes, `hostLbN`=0 writes `hostWdata[7:0]` and `hostUbN`=0 writes `hostWdata[15:8]`. A lane whose enable is 1 keeps its old value.
- R4: A host write commits once, when the write strobe or chip select is released, whichever is first. A write strobe pulsed while `hostCsN` is 1 changes nothing.
- R5: The register index is `hostAddr[4:1]` in the range 0x800–0x81E. The indices are: 0 receive, 1 transmit, 2 command A, 3 command B, 4–7 group 1 (status, edge, enable, detect), 8 group 2 status, 10 group 2 enable, 11 group 2 detect, and 12–15 group 3 (status, edge, enable, detect). Registers read as `{8'h00, value}`. Writes take `hostWdata[7:0]` and need `hostLbN`=0.
- R6: The receive byte and the three status bytes cannot be written by the host. The core writes them through the register port at indices 0, 4, 8 and 12.
- R7: With its edge bit set, a status bit sets its detect bit on a 0-to-1 change. With its edge bit clear, it sets the detect bit in every cycle it is 1. Group 2 has no edge register and is always level.
- R8: A host write to a detect register clears the bits written as 1 and leaves the others untouched. A level-mode bit whose status is still 1 is set again at once.
- R9: `hostIrqN` is 0 exactly while some group has a detect bit and its matching enable bit both set.
- R10: Index 9 and addresses 0x820–0xFFF read as 0, and host writes to them change nothing.
- R11: The core RAM port writes on `coreRamWe` and returns `coreRamRdata` for `coreRamAddr` one cycle later. The core and the host see each other's RAM writes.
- R12: `coreRegRdata` returns the register at `coreRegAddr` one cycle later. Core writes to indices other than 0, 4, 8 and 12 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low asynchronous reset |
| hostCsN | input | 1 | Host chip select, active low |
| hostRdN | input | 1 | Host read strobe, active low |
| hostWrN | input | 1 | Host write strobe, active low |
| hostUbN | input | 1 | Upper byte write enable, active low |
| hostLbN | input | 1 | Lower byte write enable, active low |
| hostAddr | input | 12 | Host byte address |
| hostWdata | input | 16 | Host write data |
| hostRdata | output | 16 | Host read data |
| hostIrqN | output | 1 | Interrupt, active low level |
| coreRamWe | input | 1 | Core RAM write enable |
| coreRamAddr | input | 10 | Core RAM word address |
| coreRamWdata | input | 16 | Core RAM write data |
| coreRamRdata | output | 16 | Core RAM read data, one cycle latency |
| coreRegWe | input | 1 | Core register write enable |
| coreRegAddr | input | 4 | Core register index |
| coreRegWdata | input | 8 | Core register write data |
| coreRegRdata | output | 8 | Core register read data, one cycle latency |

## Verification
The bench targets the gap left by the missing group-2 edge register and the unmapped upper addresses. A decoder that aliased them would show written values instead of zero. It clears a level-mode detect bit while its status is still high. A design that let the clear win would drop the interrupt while the cause persists. It also holds an edge-mode status high across a clear, where a design that treated edge as level would re-raise the interrupt. Byte-lane writes, writes ended by chip select instead of the write strobe, and strobes without chip select are all covered. A design that committed twice or without selection would corrupt the neighbouring lane or word.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int HOST_AW  = 12;
  localparam int DATA_W   = 16;
  localparam int RAM_AW   = 10;
  localparam int RAM_WORDS = 1 << RAM_AW;
  localparam int REG_IW   = 4;
  localparam int REG_N    = 1 << REG_IW;
  localparam int REG_W    = 8;
  localparam int GRP_N    = 3;

  typedef struct packed {
    logic                commit;
    logic                rdActive;
    logic                isReg;
    logic                regMapped;
    logic [1:0]          laneEn;
    logic [RAM_AW-1:0]   wordIdx;
    logic [REG_IW-1:0]   regIdx;
    logic [DATA_W-1:0]   wdata;
  } hostOp_t;
endpackage

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
  import mbx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                hostCsN,
  input  logic                hostRdN,
  input  logic                hostWrN,
  input  logic                hostUbN,
  input  logic                hostLbN,
  input  logic [HOST_AW-1:0]  hostAddr,
  input  logic [DATA_W-1:0]   hostWdata,
  output hostOp_t             hostOp
);
  localparam int UNMAP_HI = HOST_AW - 2;
  localparam int UNMAP_LO = REG_IW + 1;

  logic [SYNC_STAGES-1:0] csSync, rdSync, wrSync;
  logic wrAct, rdAct, accAct, wrActD, accActD;
  logic [HOST_AW-1:0] addrCap;
  logic [DATA_W-1:0]  dataCap;
  logic [1:0]         laneCap;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csSync <= '1;
      rdSync <= '1;
      wrSync <= '1;
    end else begin
      csSync <= {csSync[SYNC_STAGES-2:0], hostCsN};
      rdSync <= {rdSync[SYNC_STAGES-2:0], hostRdN};
      wrSync <= {wrSync[SYNC_STAGES-2:0], hostWrN};
    end
  end

  assign wrAct  = !csSync[SYNC_STAGES-1] && !wrSync[SYNC_STAGES-1];
  assign rdAct  = !csSync[SYNC_STAGES-1] && !rdSync[SYNC_STAGES-1];
  assign accAct = wrAct || rdAct;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrActD  <= 1'b0;
      accActD <= 1'b0;
      addrCap <= '0;
      dataCap <= '0;
      laneCap <= '0;
    end else begin
      wrActD  <= wrAct;
      accActD <= accAct;
      if (accAct && !accActD) begin
        addrCap <= hostAddr;
        dataCap <= hostWdata;
        laneCap <= {!hostUbN, !hostLbN};
      end
    end
  end

  always_comb begin
    hostOp.commit    = wrActD && !wrAct;
    hostOp.rdActive  = rdAct && accActD;
    hostOp.isReg     = addrCap[HOST_AW-1];
    hostOp.regMapped = (addrCap[UNMAP_HI:UNMAP_LO] == '0);
    hostOp.laneEn    = laneCap;
    hostOp.wordIdx   = addrCap[RAM_AW:1];
    hostOp.regIdx    = addrCap[REG_IW:1];
    hostOp.wdata     = dataCap;
  end

  a_r4_single_commit: assert property (@(posedge clk) disable iff (!rstN)
    hostOp.commit |=> !hostOp.commit);
  a_r4_no_read_commit: assert property (@(posedge clk) disable iff (!rstN)
    hostOp.rdActive |-> !hostOp.commit);
endmodule

// File: rtl/mbx_statgrp.sv
module mbx_statgrp #(
  parameter int W        = 8,
  parameter bit HAS_EDGE = 1'b1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         coreStatWe,
  input  logic [W-1:0] coreStatData,
  input  logic         hostEdgeWe,
  input  logic         hostEnWe,
  input  logic         hostDetClr,
  input  logic [W-1:0] hostWdata,
  output logic [W-1:0] status,
  output logic [W-1:0] edgeSel,
  output logic [W-1:0] enable,
  output logic [W-1:0] detect,
  output logic         irqReq
);
  logic [W-1:0] prevStat, setMask, clrMask;

  generate
    if (HAS_EDGE) begin : gEdge
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) edgeSel <= '0;
        else if (hostEdgeWe) edgeSel <= hostWdata;
      end
    end else begin : gLevel
      assign edgeSel = '0;
    end
  endgenerate

  assign setMask = (status & ~prevStat & edgeSel) | (status & ~edgeSel);
  assign clrMask = hostDetClr ? hostWdata : '0;
  assign irqReq  = |(detect & enable);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      status   <= '0;
      prevStat <= '0;
      enable   <= '0;
      detect   <= '0;
    end else begin
      if (coreStatWe) status <= coreStatData;
      prevStat <= status;
      if (hostEnWe) enable <= hostWdata;
      detect <= (detect & ~clrMask) | setMask;
    end
  end

  a_r7_level_sets: assert property (@(posedge clk) disable iff (!rstN)
    ((status & ~edgeSel) != '0) |=>
      ((detect & $past(status & ~edgeSel)) == $past(status & ~edgeSel)));
  a_r7_edge_sets: assert property (@(posedge clk) disable iff (!rstN)
    ((status & ~prevStat & edgeSel) != '0) |=>
      ((detect & $past(status & ~prevStat & edgeSel)) == $past(status & ~prevStat & edgeSel)));
  a_r8_clear_works: assert property (@(posedge clk) disable iff (!rstN)
    (hostDetClr && status == '0 && !coreStatWe) |=> ((detect & $past(hostWdata)) == '0));
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rstN)
    !hostDetClr |=> ((detect & $past(detect)) == $past(detect)));
endmodule

// File: rtl/mbx_datapath.sv
module mbx_datapath
  import mbx_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  hostOp_t             hostOp,
  output logic [DATA_W-1:0]   hostRdata,
  output logic                hostIrqN,
  input  logic                coreRamWe,
  input  logic [RAM_AW-1:0]   coreRamAddr,
  input  logic [DATA_W-1:0]   coreRamWdata,
  output logic [DATA_W-1:0]   coreRamRdata,
  input  logic                coreRegWe,
  input  logic [REG_IW-1:0]   coreRegAddr,
  input  logic [REG_W-1:0]    coreRegWdata,
  output logic [REG_W-1:0]    coreRegRdata
);
  localparam int HALF = DATA_W / 2;

  logic [DATA_W-1:0] ram [RAM_WORDS];
  logic [REG_W-1:0]  regView [REG_N];
  logic [REG_W-1:0]  rxData, txData, cmdA, cmdB;
  logic [REG_W-1:0]  stat [GRP_N];
  logic [REG_W-1:0]  edgeV [GRP_N];
  logic [REG_W-1:0]  enV [GRP_N];
  logic [REG_W-1:0]  detV [GRP_N];
  logic [GRP_N-1:0]  irqReq;
  logic ramWr, regWr;

  assign ramWr = hostOp.commit && !hostOp.isReg;
  assign regWr = hostOp.commit && hostOp.isReg && hostOp.regMapped && hostOp.laneEn[0];

  always_ff @(posedge clk) begin
    if (coreRamWe) ram[coreRamAddr] <= coreRamWdata;
    if (ramWr && hostOp.laneEn[0]) ram[hostOp.wordIdx][HALF-1:0] <= hostOp.wdata[HALF-1:0];
    if (ramWr && hostOp.laneEn[1]) ram[hostOp.wordIdx][DATA_W-1:HALF] <= hostOp.wdata[DATA_W-1:HALF];
    coreRamRdata <= ram[coreRamAddr];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData <= '0;
      txData <= '0;
      cmdA   <= '0;
      cmdB   <= '0;
    end else begin
      if (coreRegWe && coreRegAddr == '0) rxData <= coreRegWdata;
      if (regWr && hostOp.regIdx == REG_IW'(1)) txData <= hostOp.wdata[REG_W-1:0];
      if (regWr && hostOp.regIdx == REG_IW'(2)) cmdA   <= hostOp.wdata[REG_W-1:0];
      if (regWr && hostOp.regIdx == REG_IW'(3)) cmdB   <= hostOp.wdata[REG_W-1:0];
    end
  end

  assign regView[0] = rxData;
  assign regView[1] = txData;
  assign regView[2] = cmdA;
  assign regView[3] = cmdB;

  for (genvar g = 0; g < GRP_N; g++) begin : gGrp
    localparam int BASE = 4 + 4 * g;
    mbx_statgrp #(.W(REG_W), .HAS_EDGE(g != 1)) uGrp (
      .clk          (clk),
      .rstN         (rstN),
      .coreStatWe   (coreRegWe && coreRegAddr == REG_IW'(BASE)),
      .coreStatData (coreRegWdata),
      .hostEdgeWe   (regWr && hostOp.regIdx == REG_IW'(BASE + 1)),
      .hostEnWe     (regWr && hostOp.regIdx == REG_IW'(BASE + 2)),
      .hostDetClr   (regWr && hostOp.regIdx == REG_IW'(BASE + 3)),
      .hostWdata    (hostOp.wdata[REG_W-1:0]),
      .status       (stat[g]),
      .edgeSel      (edgeV[g]),
      .enable       (enV[g]),
      .detect       (detV[g]),
      .irqReq       (irqReq[g])
    );
    assign regView[BASE]     = stat[g];
    assign regView[BASE + 1] = edgeV[g];
    assign regView[BASE + 2] = enV[g];
    assign regView[BASE + 3] = detV[g];
  end

  assign hostIrqN = ~|irqReq;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hostRdata    <= '0;
      coreRegRdata <= '0;
    end else begin
      coreRegRdata <= regView[coreRegAddr];
      if (hostOp.rdActive) begin
        if (!hostOp.isReg) hostRdata <= ram[hostOp.wordIdx];
        else if (hostOp.regMapped) hostRdata <= {{(DATA_W-REG_W){1'b0}}, regView[hostOp.regIdx]};
        else hostRdata <= '0;
      end
    end
  end

  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rstN)
    (hostOp.rdActive && hostOp.isReg && !hostOp.regMapped) |=> (hostRdata == '0));
  a_r6_rx_readonly: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && hostOp.regIdx == '0 && !coreRegWe) |=> $stable(rxData));
  a_r5_reg_read_high_zero: assert property (@(posedge clk) disable iff (!rstN)
    (hostOp.rdActive && hostOp.isReg) |=> (hostRdata[DATA_W-1:REG_W] == '0));
  a_r9_irq_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    (enV[0] == '0 && enV[1] == '0 && enV[2] == '0) |-> hostIrqN);
endmodule

// File: rtl/mbx_top.sv
module mbx_top
  import mbx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                hostCsN,
  input  logic                hostRdN,
  input  logic                hostWrN,
  input  logic                hostUbN,
  input  logic                hostLbN,
  input  logic [11:0]         hostAddr,
  input  logic [15:0]         hostWdata,
  output logic [15:0]         hostRdata,
  output logic                hostIrqN,
  input  logic                coreRamWe,
  input  logic [9:0]          coreRamAddr,
  input  logic [15:0]         coreRamWdata,
  output logic [15:0]         coreRamRdata,
  input  logic                coreRegWe,
  input  logic [3:0]          coreRegAddr,
  input  logic [7:0]          coreRegWdata,
  output logic [7:0]          coreRegRdata
);
  hostOp_t hostOp;

  mbx_ctrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .hostCsN   (hostCsN),
    .hostRdN   (hostRdN),
    .hostWrN   (hostWrN),
    .hostUbN   (hostUbN),
    .hostLbN   (hostLbN),
    .hostAddr  (hostAddr),
    .hostWdata (hostWdata),
    .hostOp    (hostOp)
  );

  mbx_datapath uData (
    .clk          (clk),
    .rstN         (rstN),
    .hostOp       (hostOp),
    .hostRdata    (hostRdata),
    .hostIrqN     (hostIrqN),
    .coreRamWe    (coreRamWe),
    .coreRamAddr  (coreRamAddr),
    .coreRamWdata (coreRamWdata),
    .coreRamRdata (coreRamRdata),
    .coreRegWe    (coreRegWe),
    .coreRegAddr  (coreRegAddr),
    .coreRegWdata (coreRegWdata),
    .coreRegRdata (coreRegRdata)
  );
endmodule

// File: tb/mbx_top_test.sv
module mbx_top_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostCsN = 1'b1, hostRdN = 1'b1, hostWrN = 1'b1, hostUbN = 1'b1, hostLbN = 1'b1;
  logic [11:0] hostAddr = '0;
  logic [15:0] hostWdata = '0;
  logic [15:0] hostRdata;
  logic hostIrqN;
  logic coreRamWe = 1'b0;
  logic [9:0] coreRamAddr = '0;
  logic [15:0] coreRamWdata = '0;
  logic [15:0] coreRamRdata;
  logic coreRegWe = 1'b0;
  logic [3:0] coreRegAddr = '0;
  logic [7:0] coreRegWdata = '0;
  logic [7:0] coreRegRdata;

  int nChecks = 0;
  int nFails = 0;
  bit irqCheckOn = 1'b0;
  bit done = 1'b0;

  // behavioural reference state
  logic [15:0] ramM [int];
  logic [7:0] rxM = 0, txM = 0, cmdAM = 0, cmdBM = 0;
  logic [7:0] stM [3] = '{0, 0, 0};
  logic [7:0] edM [3] = '{0, 0, 0};
  logic [7:0] enM [3] = '{0, 0, 0};
  logic [7:0] dtM [3] = '{0, 0, 0};

  always #4 clk = ~clk;

  mbx_top uut (.*);

  function automatic bit modelIrqN();
    for (int g = 0; g < 3; g++) if ((dtM[g] & enM[g]) != 0) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic [7:0] regM(input int idx);
    int g;
    if (idx < 4) return (idx == 0) ? rxM : (idx == 1) ? txM : (idx == 2) ? cmdAM : cmdBM;
    if (idx == 9) return 8'h00;
    g = idx / 4 - 1;
    case (idx % 4)
      0: return stM[g];
      1: return edM[g];
      2: return enM[g];
      default: return dtM[g];
    endcase
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // per-clock comparison of the interrupt against the reference model (R9)
  always @(negedge clk) begin
    if (irqCheckOn && rstN) check("R9 irq level", {15'd0, hostIrqN}, {15'd0, modelIrqN()});
  end

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hostWrite(input logic [11:0] a, input logic [15:0] d,
                           input logic ubN, input logic lbN, input bit csFirst, input bit withCs);
    int idx, g;
    irqCheckOn = 1'b0;
    @(negedge clk);
    hostAddr = a; hostWdata = d; hostUbN = ubN; hostLbN = lbN;
    hostCsN = !withCs; hostWrN = 1'b0;
    waitN(5);
    if (csFirst) hostCsN = 1'b1; else hostWrN = 1'b1;
    waitN(5);
    hostCsN = 1'b1; hostWrN = 1'b1; hostUbN = 1'b1; hostLbN = 1'b1;
    waitN(4);
    if (withCs) begin
      if (!a[11]) begin
        logic [15:0] w;
        w = ramM.exists(int'(a[10:1])) ? ramM[int'(a[10:1])] : 16'h0;
        if (!lbN) w[7:0] = d[7:0];
        if (!ubN) w[15:8] = d[15:8];
        ramM[int'(a[10:1])] = w;
      end else if (a[10:5] == 0 && !lbN) begin
        idx = int'(a[4:1]);
        if (idx == 1) txM = d[7:0];
        else if (idx == 2) cmdAM = d[7:0];
        else if (idx == 3) cmdBM = d[7:0];
        else if (idx >= 4 && idx != 9) begin
          g = idx / 4 - 1;
          case (idx % 4)
            1: edM[g] = d[7:0];
            2: enM[g] = d[7:0];
            3: dtM[g] = dtM[g] & ~d[7:0];
            default: ;
          endcase
          dtM[g] = dtM[g] | (stM[g] & ~edM[g]);
        end
      end
    end
    irqCheckOn = 1'b1;
  endtask

  task automatic hostRead(input logic [11:0] a, output logic [15:0] d);
    @(negedge clk);
    hostAddr = a; hostUbN = 1'b1; hostLbN = 1'b1;
    hostCsN = 1'b0; hostRdN = 1'b0;
    waitN(6);
    d = hostRdata;
    hostCsN = 1'b1; hostRdN = 1'b1;
    waitN(4);
  endtask

  task automatic coreStatus(input int idx, input logic [7:0] v);
    int g;
    irqCheckOn = 1'b0;
    @(negedge clk);
    coreRegWe = 1'b1; coreRegAddr = 4'(idx); coreRegWdata = v;
    @(negedge clk);
    coreRegWe = 1'b0;
    waitN(3);
    if (idx == 0) rxM = v;
    else if (idx == 4 || idx == 8 || idx == 12) begin
      g = idx / 4 - 1;
      dtM[g] = dtM[g] | (v & ~stM[g] & edM[g]) | (v & ~edM[g]);
      stM[g] = v;
    end
    irqCheckOn = 1'b1;
  endtask

  task automatic coreRegRead(input int idx, output logic [7:0] v);
    @(negedge clk);
    coreRegAddr = 4'(idx);
    @(negedge clk);
    v = coreRegRdata;
  endtask

  initial begin
    logic [15:0] rd;
    logic [7:0] cr;
    waitN(3);
    rstN = 1'b1;
    waitN(2);
    // R1 reset state
    check("R1 irq after reset", {15'd0, hostIrqN}, 16'd1);
    check("R1 rdata after reset", hostRdata, 16'h0);
    irqCheckOn = 1'b1;
    for (int i = 0; i < 16; i++) begin
      coreRegRead(i, cr);
      check("R1 register reset / R12 core read", {8'h0, cr}, 16'h0);
    end

    // R2 word writes at both ends of RAM
    hostWrite(12'h000, 16'hA55A, 1'b0, 1'b0, 1'b0, 1'b1);
    hostWrite(12'h7FE, 16'h1234, 1'b0, 1'b0, 1'b0, 1'b1);
    hostRead(12'h000, rd); check("R2 word 0", rd, ramM[0]);
    hostRead(12'h7FE, rd); check("R2 last word", rd, ramM[1023]);

    // R3 byte lanes
    hostWrite(12'h000, 16'hFF00, 1'b0, 1'b1, 1'b0, 1'b1);
    hostRead(12'h000, rd); check("R3 upper lane only", rd, 16'hFF5A);
    hostWrite(12'h000, 16'h00C3, 1'b1, 1'b0, 1'b0, 1'b1);
    hostRead(12'h000, rd); check("R3 lower lane only", rd, 16'hFFC3);

    // R4 chip select released first, and strobe without select
    hostWrite(12'h010, 16'hBEEF, 1'b0, 1'b0, 1'b1, 1'b1);
    hostRead(12'h010, rd); check("R4 cs-ended write", rd, 16'hBEEF);
    hostWrite(12'h010, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0);
    hostRead(12'h010, rd); check("R4 write without select ignored", rd, 16'hBEEF);

    // R5 register writes and lanes
    hostWrite(12'h802, 16'hAB5C, 1'b0, 1'b0, 1'b0, 1'b1);
    hostRead(12'h802, rd); check("R5 transmit byte", rd, {8'h0, txM});
    hostWrite(12'h804, 16'h0077, 1'b0, 1'b1, 1'b0, 1'b1);
    hostRead(12'h804, rd); check("R5 command A needs lower lane", rd, 16'h0000);
    hostWrite(12'h806, 16'h0091, 1'b1, 1'b0, 1'b0, 1'b1);
    hostRead(12'h806, rd); check("R5 command B", rd, 16'h0091);
    coreRegRead(1, cr); check("R12 core sees transmit", {8'h0, cr}, 16'h005C);

    // R6 read-only registers; core writes receive byte
    hostWrite(12'h800, 16'h00EE, 1'b0, 1'b0, 1'b0, 1'b1);
    hostRead(12'h800, rd); check("R6 receive host write ignored", rd, 16'h0000);
    coreStatus(0, 8'h3C);
    hostRead(12'h800, rd); check("R6 receive from core", rd, 16'h003C);
    hostWrite(12'h808, 16'h00FF, 1'b0, 1'b0, 1'b0, 1'b1);
    hostRead(12'h808, rd); check("R6 status host write ignored", rd, 16'h0000);
    coreStatus(2, 8'h44);
    coreRegRead(2, cr); check("R12 core write to command ignored", {8'h0, cr}, 16'h0000);

    // R7/R8/R9 edge mode, group 1
    hostWrite(12'h80A, 16'h0001, 1'b1, 1'b0, 1'b0, 1'b1);
    hostWrite(12'h80C, 16'h0001, 1'b1, 1'b0, 1'b0, 1'b1);
    coreStatus(4, 8'h01);
    hostRead(12'h80E, rd); check("R7 edge sets detect", rd, 16'h0001);
    check("R9 irq asserted", {15'd0, hostIrqN}, 16'd0);
    hostWrite(12'h80E, 16'h0001, 1'b1, 1'b0, 1'b0, 1'b1);
    hostRead(12'h80E, rd); check("R8 edge detect cleared while status high", rd, 16'h0000);
    check("R9 irq released", {15'd0, hostIrqN}, 16'd1);

    // R7/R8 level mode, group 3
    hostWrite(12'h81C, 16'h0004, 1'b1, 1'b0, 1'b0, 1'b1);
    coreStatus(12, 8'h04);
    hostRead(12'h81E, rd); check("R7 level sets detect", rd, 16'h0004);
    hostWrite(12'h81E, 16'h0004, 1'b1, 1'b0, 1'b0, 1'b1);
    hostRead(12'h81E, rd); check("R8 level re-sets while status high", rd, 16'h0004);
    check("R9 irq held by level", {15'd0, hostIrqN}, 16'd0);
    coreStatus(12, 8'h00);
    hostWrite(12'h81E, 16'h0004, 1'b1, 1'b0, 1'b0, 1'b1);
    hostRead(12'h81E, rd); check("R8 level clears once low", rd, 16'h0000);

    // R7/R10 group 2: no edge register, enable off keeps irq released
    hostWrite(12'h812, 16'h00FF, 1'b1, 1'b0, 1'b0, 1'b1);
    hostRead(12'h812, rd); check("R10 index 9 reads zero", rd, 16'h0000);
    coreStatus(8, 8'h80);
    hostRead(12'h816, rd); check("R7 group 2 level detect", rd, 16'h0080);
    check("R9 disabled detect leaves irq high", {15'd0, hostIrqN}, 16'd1);
    hostWrite(12'h814, 16'h0080, 1'b1, 1'b0, 1'b0, 1'b1);
    check("R9 enabling raises irq", {15'd0, hostIrqN}, 16'd0);
    coreStatus(8, 8'h00);
    hostWrite(12'h816, 16'h0080, 1'b1, 1'b0, 1'b0, 1'b1);
    check("R9 irq released after clear", {15'd0, hostIrqN}, 16'd1);

    // R10 unmapped upper range
    hostWrite(12'h820, 16'h0055, 1'b0, 1'b0, 1'b0, 1'b1);
    hostRead(12'h820, rd); check("R10 0x820 reads zero", rd, 16'h0000);
    hostWrite(12'hFFE, 16'h0066, 1'b0, 1'b0, 1'b0, 1'b1);
    hostRead(12'hFFE, rd); check("R10 0xFFE reads zero", rd, 16'h0000);
    hostRead(12'h802, rd); check("R10 no alias into transmit", rd, {8'h0, regM(1)});

    // R11 core RAM port
    @(negedge clk); coreRamAddr = 10'd8;
    @(negedge clk); check("R11 core reads host word", coreRamRdata, 16'hBEEF);
    coreRamWe = 1'b1; coreRamAddr = 10'd20; coreRamWdata = 16'h5AA5;
    @(negedge clk); coreRamWe = 1'b0;
    @(negedge clk); check("R11 core read after write", coreRamRdata, 16'h5AA5);
    hostRead(12'h028, rd); check("R11 host sees core word", rd, 16'h5AA5);

    for (int i = 4; i < 16; i++) begin
      coreRegRead(i, cr);
      check("R12 core register view", {8'h0, cr}, {8'h0, regM(i)});
    end
    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule